// File: doc/BRIEF.md
# Victim Line Store for a Direct-Mapped First-Level Cache

This block is a small, fully associative side store that sits next to a direct-mapped first-level cache. Every line the first-level cache throws out is written into it. When the first-level cache misses, it probes this store before anything goes to the second level. The store therefore acts as extra associativity for the few first-level sets that conflict most often.

Each entry holds a full line address (tag plus index), a valid flag, a dirty flag and one line of data. A probe compares every entry at once. On a hit, the line is handed back to the first-level cache. In the same cycle, the slot it came from is taken by the line the first-level cache is displacing, so the two lines swap places. On a miss, a read request goes to the second level, and any line evicted in that cycle is inserted. The insert goes to the lowest free slot. When no slot is free, it goes to the slot named by a round-robin pointer. A dirty line pushed out of the store is sent to the second level as a write-back in the same response cycle, taken from the slot's old contents.

All results are registered and appear exactly one clock after the request that caused them. Each result lasts a single cycle.

Top module: `vc_victim_cache`

## Requirements
- R1: While `rst` is high, and on the clock after it, `hit_valid`, `l2_req_valid` and `wb_valid` are 0. A reset empties the store, so a probe for any earlier line misses.
- R2: A probe (`lk_valid`=1) whose address matches a valid entry raises `hit_valid` one clock later. That cycle also carries the entry's stored line on `hit_data` and its dirty flag on `hit_dirty`, and no second-level request is made.
- R3: A probe that matches no valid entry raises `l2_req_valid` one clock later with `l2_req_addr` equal to the probed address, and `hit_valid` stays 0. Every probe produces exactly one of these two results.
- R4: On a probe hit accompanied by an eviction (`ev_valid`=1), the evicted line takes the hit entry's slot. A later probe for the evicted address hits with its data and dirty flag, and this swap never produces a write-back.
- R5: A probe hit always removes the returned entry, so an immediately repeated probe for the same address misses.
- R6: An eviction presented without a probe, or alongside a missing probe, is inserted into the store, using a free slot whenever one exists and displacing nothing.
- R7: When the store is full, an insert replaces the slot at a round-robin pointer. The pointer starts at slot 0 after reset and advances by one, wrapping after slot ENTRIES-1, only on such a replacement.
- R8: A replacement that displaces a dirty entry raises `wb_valid` one clock later, with that entry's address and line on `wb_addr`/`wb_data`. Displacing a clean entry raises no write-back.
- R9: The store keeps up to ENTRIES (default 4) lines at once, and each stays retrievable until it is hit, replaced or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Probe request from the first-level miss logic |
| lk_addr | input | ADDR_W | Line address being probed |
| ev_valid | input | 1 | A line is being evicted from the first level this cycle |
| ev_addr | input | ADDR_W | Line address of the evicted line |
| ev_dirty | input | 1 | Evicted line is modified |
| ev_data | input | LINE_BYTES*8 | Evicted line contents |
| hit_valid | output | 1 | Probe hit; line returned |
| hit_dirty | output | 1 | Dirty flag of the returned line |
| hit_data | output | LINE_BYTES*8 | Returned line contents |
| l2_req_valid | output | 1 | Read request to the second level after a probe miss |
| l2_req_addr | output | ADDR_W | Address of the second-level read |
| wb_valid | output | 1 | Dirty line displaced from the store, write back |
| wb_addr | output | ADDR_W | Address of the written-back line |
| wb_data | output | LINE_BYTES*8 | Contents of the written-back line |

## Verification
Every result of this block is due one clock after the inputs that cause it: a hit, a second-level request, or a write-back. The bench drives inputs on the falling edge, lets one rising edge consume them, and compares all three result groups at the next falling edge. A result that arrives a cycle early or late therefore shows up as a miscompare, whether it is missing or stray. Round-robin order and the dirty write-back are checked through the sequence of write-back addresses that a run of inserts into a full store produces.

// File: rtl/vc_pkg.sv
package vc_pkg;
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/vc_match.sv
module vc_match #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26,
  localparam int IDX_W  = vc_pkg::idx_width(ENTRIES)
) (
  input  logic [ENTRIES-1:0]             vld,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] tags,
  input  logic [ADDR_W-1:0]              addr,
  output logic [ENTRIES-1:0]             match_vec,
  output logic                           any_hit,
  output logic [IDX_W-1:0]               hit_idx
);
  // one comparator per entry, all in parallel
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = vld[g] && (tags[g] == addr);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match_vec[i]) hit_idx = IDX_W'(i);
  end

  assign any_hit = |match_vec;
endmodule

// File: rtl/vc_alloc.sv
module vc_alloc #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = vc_pkg::idx_width(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] vld,
  input  logic               take,
  output logic [IDX_W-1:0]   slot_idx,
  output logic               slot_used
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             has_free;

  // lowest-numbered free slot
  always_comb begin
    free_idx = '0;
    has_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld[i]) begin
        free_idx = IDX_W'(i);
        has_free = 1'b1;
      end
  end

  assign slot_idx  = has_free ? free_idx : rr_q;
  assign slot_used = !has_free;

  // pointer moves only when a full store is overwritten
  always_ff @(posedge clk) begin
    if (rst)
      rr_q <= '0;
    else if (take && !has_free)
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

  p_rr_range_r7: assert property (@(posedge clk) disable iff (rst)
    32'(rr_q) < ENTRIES);
  p_rr_step_r7: assert property (@(posedge clk) disable iff (rst)
    (take && !has_free && rr_q != IDX_W'(ENTRIES - 1)) |=> rr_q == $past(rr_q) + 1'b1);
endmodule

// File: rtl/vc_victim_cache.sv
module vc_victim_cache #(
  parameter int ENTRIES    = 4,
  parameter int ADDR_W     = 26,
  parameter int LINE_BYTES = 32,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int IDX_W     = vc_pkg::idx_width(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              ev_valid,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              ev_dirty,
  input  logic [LINE_W-1:0] ev_data,
  output logic              hit_valid,
  output logic              hit_dirty,
  output logic [LINE_W-1:0] hit_data,
  output logic              l2_req_valid,
  output logic [ADDR_W-1:0] l2_req_addr,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [LINE_W-1:0] wb_data
);
  // entry state
  logic [ENTRIES-1:0]             vld_q;
  logic [ENTRIES-1:0]             dty_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
  logic [LINE_W-1:0]              data_q [ENTRIES];

  logic [ENTRIES-1:0] match_vec;
  logic               any_hit;
  logic [IDX_W-1:0]   hit_idx;
  logic [IDX_W-1:0]   slot_idx;
  logic               slot_used;

  vc_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) i_match (
    .vld(vld_q), .tags(tag_q), .addr(lk_addr),
    .match_vec(match_vec), .any_hit(any_hit), .hit_idx(hit_idx)
  );

  logic swap;
  logic take;
  logic [IDX_W-1:0] wr_idx;
  logic displace_dirty;

  assign swap           = lk_valid && any_hit;
  assign take           = ev_valid && !swap;
  assign wr_idx         = swap ? hit_idx : slot_idx;
  assign displace_dirty = take && slot_used && dty_q[slot_idx];

  vc_alloc #(.ENTRIES(ENTRIES)) i_alloc (
    .clk(clk), .rst(rst), .vld(vld_q), .take(take),
    .slot_idx(slot_idx), .slot_used(slot_used)
  );

  // line data: one write port, no reset
  always_ff @(posedge clk) begin
    if (ev_valid) data_q[wr_idx] <= ev_data;
  end

  // tags and flags
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      dty_q <= '0;
      tag_q <= '0;
    end else begin
      if (swap && !ev_valid) vld_q[hit_idx] <= 1'b0;
      if (ev_valid) begin
        vld_q[wr_idx] <= 1'b1;
        dty_q[wr_idx] <= ev_dirty;
        tag_q[wr_idx] <= ev_addr;
      end
    end
  end

  // registered results, read from the pre-write contents
  always_ff @(posedge clk) begin
    if (rst) begin
      hit_valid    <= 1'b0;
      l2_req_valid <= 1'b0;
      wb_valid     <= 1'b0;
    end else begin
      hit_valid    <= swap;
      l2_req_valid <= lk_valid && !any_hit;
      wb_valid     <= displace_dirty;
    end
    hit_dirty   <= dty_q[hit_idx];
    hit_data    <= data_q[hit_idx];
    l2_req_addr <= lk_addr;
    wb_addr     <= tag_q[slot_idx];
    wb_data     <= data_q[slot_idx];
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> !hit_valid && !l2_req_valid && !wb_valid);
  p_one_result_r2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (hit_valid ^ l2_req_valid));
  p_hit_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(hit_valid && l2_req_valid));
  p_miss_addr_r3: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !any_hit) |=> l2_req_addr == $past(lk_addr));
  p_unique_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec));
  p_swap_no_wb_r4: assert property (@(posedge clk) disable iff (rst)
    swap |=> !wb_valid);
  p_wb_cause_r8: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> $past(ev_valid && !swap));
endmodule

// File: tb/test_vc_victim_cache.sv
module test_vc_victim_cache;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 26;
  localparam int LW = 256;
  localparam int NV = 26;

  typedef struct packed {
    logic          lk;
    logic [AW-1:0] la;
    logic          ev;
    logic [AW-1:0] ea;
    logic          ed;
    logic          xh;
    logic          xd;
    logic          xm;
    logic          xw;
    logic [AW-1:0] xa;
  } vec_t;

  // lk la  ev ea  ed | hit dirty miss wb wbaddr
  localparam vec_t VEC [NV] = '{
    '{1'b1, 26'h10, 1'b0, 26'h0,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 26'h0 },  // 0  R3 empty miss
    '{1'b0, 26'h0,  1'b1, 26'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0 },  // 1  R6
    '{1'b0, 26'h0,  1'b1, 26'h12, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0 },  // 2  R6
    '{1'b1, 26'h11, 1'b0, 26'h0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 26'h0 },  // 3  R2 clean hit
    '{1'b1, 26'h11, 1'b0, 26'h0,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 26'h0 },  // 4  R5 removed
    '{1'b1, 26'h12, 1'b1, 26'h20, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 26'h0 },  // 5  R4 swap
    '{1'b1, 26'h30, 1'b1, 26'h12, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 26'h0 },  // 6  R6 miss+insert
    '{1'b1, 26'h20, 1'b0, 26'h0,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 26'h0 },  // 7  R4 swapped-in line
    '{1'b1, 26'h12, 1'b0, 26'h0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 26'h0 },  // 8  R4 now clean
    '{1'b0, 26'h0,  1'b1, 26'h40, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0 },  // 9  R9 fill
    '{1'b0, 26'h0,  1'b1, 26'h41, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0 },  // 10
    '{1'b0, 26'h0,  1'b1, 26'h42, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0 },  // 11
    '{1'b0, 26'h0,  1'b1, 26'h43, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0 },  // 12 full
    '{1'b0, 26'h0,  1'b1, 26'h44, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 26'h40},  // 13 R7 slot0 R8
    '{1'b1, 26'h50, 1'b1, 26'h45, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 26'h0 },  // 14 R8 clean, no wb
    '{1'b0, 26'h0,  1'b1, 26'h46, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 26'h42},  // 15 R7 slot2
    '{1'b1, 26'h44, 1'b0, 26'h0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 26'h0 },  // 16 frees slot0
    '{1'b0, 26'h0,  1'b1, 26'h47, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0 },  // 17 R6 free first
    '{1'b0, 26'h0,  1'b1, 26'h48, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 26'h43},  // 18 R7 slot3
    '{1'b0, 26'h0,  1'b1, 26'h49, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 26'h47},  // 19 R7 wrap slot0
    '{1'b1, 26'h45, 1'b0, 26'h0,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 26'h0 },  // 20 R9
    '{1'b1, 26'h46, 1'b0, 26'h0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 26'h0 },  // 21 R9
    '{1'b1, 26'h48, 1'b0, 26'h0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 26'h0 },  // 22 R9
    '{1'b1, 26'h49, 1'b0, 26'h0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 26'h0 },  // 23 R9
    '{1'b1, 26'h45, 1'b0, 26'h0,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 26'h0 },  // 24 R5
    '{1'b0, 26'h0,  1'b0, 26'h0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0 }   // 25 idle
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lk_valid = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic          ev_valid = 1'b0;
  logic [AW-1:0] ev_addr = '0;
  logic          ev_dirty = 1'b0;
  logic [LW-1:0] ev_data = '0;
  logic          hit_valid, hit_dirty, l2_req_valid, wb_valid;
  logic [LW-1:0] hit_data, wb_data;
  logic [AW-1:0] l2_req_addr, wb_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vc_victim_cache i_vc_victim_cache (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_dirty(ev_dirty), .ev_data(ev_data),
    .hit_valid(hit_valid), .hit_dirty(hit_dirty), .hit_data(hit_data),
    .l2_req_valid(l2_req_valid), .l2_req_addr(l2_req_addr),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  function automatic logic [LW-1:0] line_of(input logic [AW-1:0] a);
    return {8{6'h2A, a}};
  endfunction

  task automatic check(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    lk_valid = v.lk;
    lk_addr  = v.la;
    ev_valid = v.ev;
    ev_addr  = v.ea;
    ev_dirty = v.ed;
    ev_data  = line_of(v.ea);
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    ev_valid = 1'b0;
  endtask

  task automatic check_vec(input int k, input vec_t v);
    string tag;
    logic ok;
    tag = $sformatf("R2/R3/R8 vector %0d", k);
    ok = (hit_valid === v.xh) && (l2_req_valid === v.xm) && (wb_valid === v.xw);
    if (ok && v.xh) ok = (hit_dirty === v.xd) && (hit_data === line_of(v.la));
    if (ok && v.xm) ok = (l2_req_addr === v.la);
    if (ok && v.xw) ok = (wb_addr === v.xa) && (wb_data === line_of(v.xa));
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual hit=%b d=%b miss=%b wb=%b l2a=%0h wba=%0h expected hit=%b d=%b miss=%b wb=%b wba=%0h",
               tag, hit_valid, hit_dirty, l2_req_valid, wb_valid, l2_req_addr, wb_addr,
               v.xh, v.xd, v.xm, v.xw, v.xa);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    vec_t v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs quiet under reset
    check("R1 hit_valid in reset", LW'(hit_valid), '0);
    check("R1 l2_req_valid in reset", LW'(l2_req_valid), '0);
    check("R1 wb_valid in reset", LW'(wb_valid), '0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      drive(VEC[k]);
      check_vec(k, VEC[k]);
    end

    // R1: reset empties the store
    v = '0; v.ev = 1'b1; v.ea = 26'h60; v.ed = 1'b1;
    drive(v);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 wb_valid after reset", LW'(wb_valid), '0);
    rst = 1'b0;
    v = '0; v.lk = 1'b1; v.la = 26'h60;
    drive(v);
    check("R1 probe after reset misses", LW'(l2_req_valid), LW'(1'b1));
    check("R1 no hit after reset", LW'(hit_valid), '0);

    // R7: pointer restarts at slot 0 after reset
    for (int k = 0; k < 5; k++) begin
      v = '0; v.ev = 1'b1; v.ea = AW'(26'h70 + k); v.ed = 1'b1;
      drive(v);
    end
    check("R7 first replacement after reset hits slot 0", LW'(wb_addr), LW'(26'h70));
    check("R8 dirty displacement written back", LW'(wb_valid), LW'(1'b1));
    check("R8 write-back data", wb_data, line_of(26'h70));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule